// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block is the command state machine of a single-master DDR SDRAM controller. A user or test port presents an operation code, a packed bank/row/column address, an auto-precharge flag and one double-width write word. The sequencer turns each accepted operation into the bus cycles the memory needs. A read or write first opens its row with ACTIVE. A read then waits out the CAS latency before its data window, and a write runs its data window directly. The sequencer also issues single-cycle precharge, refresh and mode-load commands, each with its recovery time.

A refresh timer raises a request flag. The sequencer serves it ahead of any user operation the next time it is idle. A read can be cut short with a burst-terminate command. The block drives the chip-select, row-strobe, column-strobe and write-enable pins, the bank and address pins, and two enables for the external write and read data paths. Powering up the memory, interleaving banks and keeping rows open are left to other blocks.

Top module: `sdram_cmd_fsm`

## Requirements
- R1: After reset, busy_o is 0, rd_en_o and wr_en_o are 0, and the pins {cs_n_o,ras_n_o,cas_n_o,we_n_o} show NOP = 4'b0111.
- R2: An operation is accepted only when busy_o is 0, cmd_valid_i is 1 and rfsh_req_i is 0. A read (op_i=1) first puts ACTIVE (4'b0011) on the pins for one cycle, with ba_o equal to the bank field and a_o equal to the row field. The next cycle puts READ (4'b0101) on the pins, with a_o holding the column in its low bits, auto_pre_i in bit 10 and zeros elsewhere. addr_i is packed as {bank, row, column}.
- R3: After the READ cycle, the pins show NOP and rd_en_o is 0 for CAS_LAT cycles. rd_en_o is then 1 for BURST_LEN/2 cycles, and then busy_o returns to 0.
- R4: A write (op_i=2) puts ACTIVE on the pins and then WRITE (4'b0100), with the same address layout as a read. wr_en_o is then 1 for BURST_LEN/2 cycles, with wr_data_o equal to the wdata_i captured at acceptance. Then busy_o returns to 0. rd_en_o and wr_en_o are never 1 together.
- R5: If bterm_i is 1 during a cycle in which rd_en_o is 1, the next cycle shows BURST TERMINATE (4'b0110) with rd_en_o at 0, and the cycle after that is idle.
- R6: A precharge (op_i=3) puts PRECHARGE (4'b0010) on the pins once, with a_o bit 10 set to select all banks. The pins then show NOP, and busy_o stays 1 for T_RP cycles in total.
- R7: A refresh (op_i=4) puts AUTO REFRESH (4'b0001) on the pins once. The pins then show NOP, and busy_o stays 1 for T_RFC cycles in total.
- R8: When rfsh_req_i is 1 while the block is idle, the next cycle is AUTO REFRESH, even if an operation is offered in the same cycle. That operation is dropped.
- R9: A mode load (op_i=5) puts LOAD MODE (4'b0000) on the pins for one cycle, with ba_o equal to the bank field and a_o equal to the row field (the mode value). The block is idle in the next cycle.
- R10: An operation offered while busy_o is 1 has no effect, and so do the codes 0, 6 and 7. The pins stay NOP and busy_o stays 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Operation offered |
| op_i | input | 3 | Operation code |
| addr_i | input | BA_W+ROW_W+COL_W | Packed {bank, row, column} |
| auto_pre_i | input | 1 | Request auto precharge on read or write |
| wdata_i | input | 2*DQ_W | Write word (two beats) |
| bterm_i | input | 1 | End the current read burst early |
| rfsh_req_i | input | 1 | Refresh request from the refresh timer |
| busy_o | output | 1 | Sequencer not idle |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| a_o | output | ROW_W | Address pins |
| wr_en_o | output | 1 | Enable for the write data path |
| wr_data_o | output | 2*DQ_W | Captured write word |
| rd_en_o | output | 1 | Enable for the read data path |

## Verification
The properties assume T_RP and T_RFC are at least 2, so that a precharge or refresh is always followed by a quiet cycle. They also assume bterm_i matters only while read data is flowing, and that the refresh flag is looked at only in the idle state. The stimulus changes inputs on falling edges and keeps rfsh_req_i low outside the refresh-priority scenario. It raises bterm_i only after a cycle in which rd_en_o was seen high, and offers operations during busy periods only in the scenario that checks they are ignored.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ACT, ST_RD, ST_WR, ST_WDAT, ST_CL, ST_RDAT,
    ST_BST, ST_PRE, ST_REF, ST_LMR
  } state_e;

  localparam logic [2:0] OP_READ  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_PRE   = 3'd3;
  localparam logic [2:0] OP_REF   = 3'd4;
  localparam logic [2:0] OP_LMR   = 3'd5;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] BUS_NOP = 4'b0111;
  localparam logic [3:0] BUS_ACT = 4'b0011;
  localparam logic [3:0] BUS_RD  = 4'b0101;
  localparam logic [3:0] BUS_WR  = 4'b0100;
  localparam logic [3:0] BUS_BST = 4'b0110;
  localparam logic [3:0] BUS_PRE = 4'b0010;
  localparam logic [3:0] BUS_REF = 4'b0001;
  localparam logic [3:0] BUS_LMR = 4'b0000;
endpackage

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc import sdram_cmd_pkg::*; #(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10
) (
  input  state_e           state_i,
  input  logic             first_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ap_i,
  output logic [3:0]       bus_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] a_o
);
  logic [ROW_W-1:0] a_col;

  always_comb begin
    a_col = '0;
    a_col[COL_W-1:0] = col_i;
    a_col[AP_BIT] = ap_i;
  end

  always_comb begin
    bus_o = BUS_NOP;
    ba_o  = '0;
    a_o   = '0;
    unique case (state_i)
      ST_ACT: begin bus_o = BUS_ACT; ba_o = ba_i; a_o = row_i; end
      ST_RD:  begin bus_o = BUS_RD;  ba_o = ba_i; a_o = a_col; end
      ST_WR:  begin bus_o = BUS_WR;  ba_o = ba_i; a_o = a_col; end
      ST_BST: bus_o = BUS_BST;
      ST_LMR: begin bus_o = BUS_LMR; ba_o = ba_i; a_o = row_i; end
      ST_PRE: if (first_i) begin bus_o = BUS_PRE; a_o[AP_BIT] = 1'b1; end
      ST_REF: if (first_i) bus_o = BUS_REF;
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm import sdram_cmd_pkg::*; #(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int DQ_W      = 8,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  input  logic [2:0]                  op_i,
  input  logic [BA_W+ROW_W+COL_W-1:0] addr_i,
  input  logic                        auto_pre_i,
  input  logic [2*DQ_W-1:0]           wdata_i,
  input  logic                        bterm_i,
  input  logic                        rfsh_req_i,
  output logic                        busy_o,
  output logic                        cs_n_o,
  output logic                        ras_n_o,
  output logic                        cas_n_o,
  output logic                        we_n_o,
  output logic [BA_W-1:0]             ba_o,
  output logic [ROW_W-1:0]            a_o,
  output logic                        wr_en_o,
  output logic [2*DQ_W-1:0]           wr_data_o,
  output logic                        rd_en_o
);
  localparam int ADDR_W    = BA_W + ROW_W + COL_W;
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int M1        = (CAS_LAT > BURST_CYC) ? CAS_LAT : BURST_CYC;
  localparam int M2        = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int CNT_MAX   = (M1 > M2) ? M1 : M2;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  state_e             state_q, state_d;
  logic [2:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               ap_q;
  logic [2*DQ_W-1:0]  wd_q;
  logic [CNT_W-1:0]   cnt;
  logic               accept, op_known;
  logic [3:0]         bus;

  assign op_known = (op_i >= OP_READ) && (op_i <= OP_LMR);
  assign accept   = (state_q == ST_IDLE) && !rfsh_req_i && cmd_valid_i && op_known;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rfsh_req_i) state_d = ST_REF;
        else if (accept) begin
          unique case (op_i)
            OP_READ, OP_WRITE: state_d = ST_ACT;
            OP_PRE:            state_d = ST_PRE;
            OP_REF:            state_d = ST_REF;
            default:           state_d = ST_LMR;
          endcase
        end
      end
      ST_ACT:  state_d = (op_q == OP_READ) ? ST_RD : ST_WR;
      ST_RD:   state_d = ST_CL;
      ST_WR:   state_d = ST_WDAT;
      ST_CL:   if (cnt == CNT_W'(CAS_LAT - 1)) state_d = ST_RDAT;
      ST_RDAT: begin
        if (bterm_i) state_d = ST_BST;
        else if (cnt == CNT_W'(BURST_CYC - 1)) state_d = ST_IDLE;
      end
      ST_WDAT: if (cnt == CNT_W'(BURST_CYC - 1)) state_d = ST_IDLE;
      ST_PRE:  if (cnt == CNT_W'(T_RP - 1)) state_d = ST_IDLE;
      ST_REF:  if (cnt == CNT_W'(T_RFC - 1)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      ap_q    <= 1'b0;
      wd_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= op_i;
        addr_q <= addr_i;
        ap_q   <= auto_pre_i;
        wd_q   <= wdata_i;
      end
    end
  end

  sdram_cmd_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_d != state_q),
    .cnt_o (cnt)
  );

  sdram_cmd_enc #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) i_enc (
    .state_i(state_q),
    .first_i(cnt == '0),
    .ba_i   (addr_q[ADDR_W-1 -: BA_W]),
    .row_i  (addr_q[COL_W +: ROW_W]),
    .col_i  (addr_q[COL_W-1:0]),
    .ap_i   (ap_q),
    .bus_o  (bus),
    .ba_o   (ba_o),
    .a_o    (a_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = bus;
  assign busy_o    = (state_q != ST_IDLE);
  assign rd_en_o   = (state_q == ST_RDAT);
  assign wr_en_o   = (state_q == ST_WDAT);
  assign wr_data_o = wd_q;

  p_rw_after_act_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus == BUS_RD || bus == BUS_WR) |-> $past(bus) == BUS_ACT);
  p_cl_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> $past(bus) == BUS_NOP);
  p_en_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_o, wr_en_o}));
  p_bst_after_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus == BUS_BST |-> $past(rd_en_o) && !rd_en_o);
  p_pre_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus == BUS_PRE |=> bus == BUS_NOP && busy_o);
  p_ref_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus == BUS_REF |=> bus == BUS_NOP && busy_o);
  p_rfsh_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && rfsh_req_i) |=> bus == BUS_REF);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> bus == BUS_NOP && !rd_en_o && !wr_en_o);
endmodule

// File: tb/test_sdram_cmd_fsm.sv
`timescale 1ns/1ps
module test_sdram_cmd_fsm;
  localparam int CL = 2, BL = 4, TRP = 3, TRFC = 7, BC = BL / 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, auto_pre = 1'b0, bterm = 1'b0, rfsh = 1'b0;
  logic [2:0] op = '0;
  logic [24:0] addr = '0;
  logic [15:0] wdata = '0;
  logic busy, cs_n, ras_n, cas_n, we_n, wr_en, rd_en;
  logic [1:0] ba;
  logic [12:0] a;
  logic [15:0] wr_data;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_cmd_fsm #(.CAS_LAT(CL), .BURST_LEN(BL), .T_RP(TRP), .T_RFC(TRFC)) i_sdram_cmd_fsm (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .op_i(op), .addr_i(addr),
    .auto_pre_i(auto_pre), .wdata_i(wdata), .bterm_i(bterm), .rfsh_req_i(rfsh),
    .busy_o(busy), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .a_o(a), .wr_en_o(wr_en), .wr_data_o(wr_data), .rd_en_o(rd_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [3:0] pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  function automatic logic [12:0] colw(input logic [9:0] c, input logic ap);
    logic [12:0] r = '0;
    r[9:0] = c;
    r[10] = ap;
    return r;
  endfunction

  task automatic offer(input logic [2:0] o, input logic [1:0] b, input logic [12:0] r,
                       input logic [9:0] c, input logic ap, input logic [15:0] wd);
    cmd_valid = 1'b1; op = o; addr = {b, r, c}; auto_pre = ap; wdata = wd;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 pins", pins(), 4'b0111);
    chk("R1 enables", {rd_en, wr_en}, 0);
  endtask

  task automatic t_read(input logic [1:0] b, input logic [12:0] r, input logic [9:0] c, input logic ap);
    offer(3'd1, b, r, c, ap, 16'h0);
    chk("R2 act pins", pins(), 4'b0011);
    chk("R2 act ba/row", {ba, a}, {b, r});
    chk("R2 busy", busy, 1);
    step();
    chk("R2 read pins", pins(), 4'b0101);
    chk("R2 read ba/col", {ba, a}, {b, colw(c, ap)});
    for (int i = 0; i < CL; i++) begin
      step();
      chk("R3 latency gap", {pins(), rd_en}, {4'b0111, 1'b0});
    end
    for (int i = 0; i < BC; i++) begin
      step();
      chk("R3 read window", {rd_en, busy}, 2'b11);
    end
    step();
    chk("R3 back idle", {busy, rd_en}, 0);
  endtask

  task automatic t_write(input logic [15:0] wd);
    offer(3'd2, 2'd2, 13'h0AB, 10'h155, 1'b1, wd);
    chk("R4 act pins", pins(), 4'b0011);
    wdata = ~wd;
    step();
    chk("R4 write pins", pins(), 4'b0100);
    chk("R4 write col", {ba, a}, {2'd2, colw(10'h155, 1'b1)});
    for (int i = 0; i < BC; i++) begin
      step();
      chk("R4 write window", {wr_en, rd_en}, 2'b10);
      chk("R4 write data", wr_data, wd);
    end
    step();
    chk("R4 back idle", {busy, wr_en}, 0);
  endtask

  task automatic t_bterm();
    offer(3'd1, 2'd1, 13'h1, 10'h2, 1'b0, 16'h0);
    for (int i = 0; i < 1 + CL + 1; i++) step();
    chk("R5 first beat", rd_en, 1);
    bterm = 1'b1;
    step();
    bterm = 1'b0;
    chk("R5 terminate pins", pins(), 4'b0110);
    chk("R5 rd_en off", rd_en, 0);
    step();
    chk("R5 idle after", {busy, pins()}, {1'b0, 4'b0111});
  endtask

  task automatic t_pre();
    offer(3'd3, 2'd3, 13'h1FFF, 10'h3FF, 1'b0, 16'h0);
    chk("R6 pre pins", pins(), 4'b0010);
    chk("R6 all banks bit", a[10], 1);
    for (int i = 1; i < TRP; i++) begin
      step();
      chk("R6 wait", {busy, pins()}, {1'b1, 4'b0111});
    end
    step();
    chk("R6 done", busy, 0);
  endtask

  task automatic t_ref();
    offer(3'd4, 2'd0, 13'h0, 10'h0, 1'b0, 16'h0);
    chk("R7 ref pins", pins(), 4'b0001);
    for (int i = 1; i < TRFC; i++) begin
      step();
      chk("R7 wait", {busy, pins()}, {1'b1, 4'b0111});
    end
    step();
    chk("R7 done", busy, 0);
  endtask

  task automatic t_rfsh_prio();
    rfsh = 1'b1;
    offer(3'd1, 2'd1, 13'h55, 10'h5, 1'b0, 16'h0);
    rfsh = 1'b0;
    chk("R8 refresh first", pins(), 4'b0001);
    for (int i = 1; i < TRFC; i++) begin
      step();
      chk("R8 no activate", pins(), 4'b0111);
    end
    step();
    chk("R8 read dropped", {busy, pins()}, {1'b0, 4'b0111});
  endtask

  task automatic t_lmr();
    offer(3'd5, 2'd1, 13'h0123, 10'h0, 1'b0, 16'h0);
    chk("R9 lmr pins", pins(), 4'b0000);
    chk("R9 lmr ba/mode", {ba, a}, {2'd1, 13'h0123});
    step();
    chk("R9 idle", busy, 0);
  endtask

  task automatic t_ignore();
    offer(3'd3, 2'd0, 13'h0, 10'h0, 1'b0, 16'h0);
    cmd_valid = 1'b1; op = 3'd5;
    for (int i = 1; i < TRP; i++) begin
      step();
      chk("R10 busy offer ignored", pins(), 4'b0111);
    end
    cmd_valid = 1'b0;
    step();
    chk("R10 idle", busy, 0);
    step();
    chk("R10 no late lmr", {busy, pins()}, {1'b0, 4'b0111});
    for (int k = 6; k < 9; k++) begin
      offer(k == 8 ? 3'd0 : 3'(k), 2'd1, 13'h1, 10'h1, 1'b0, 16'h0);
      chk("R10 bad code", {busy, pins()}, {1'b0, 4'b0111});
    end
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_read(2'd1, 13'h1A5A, 10'h2C3, 1'b1);
    t_read(2'd3, 13'h0F0F, 10'h011, 1'b0);
    t_write(16'hBEEF);
    t_write(16'h1234);
    t_bterm();
    t_pre();
    t_ref();
    t_rfsh_prio();
    t_lmr();
    t_ignore();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule